// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

An 8-bit up-counter driven through a selectable power-of-two prescaler. In interval mode it acts as a periodic timer that raises a single-cycle interrupt each time it wraps. In watchdog mode a wrap records a sticky overflow flag and can ask the surrounding system for a reset, either power-on or manual, while the timer returns itself to its idle state.

Every register update is guarded. Writes count only as 16-bit transfers whose upper byte matches a fixed key, and the key also picks the register. The counter and the control register share one write address and are told apart only by their key. The overflow flag can be cleared only after software has read it as set. The host uses a small bus with an address, 16-bit write data, a size bit (word or byte), a write strobe and a read strobe, and reads back 8 bits combinationally.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, address 0 (control) reads 0x18, address 1 (counter) reads 0x00 and address 2 (reset control) reads 0x1F; irq_o, rst_req_o and rst_type_o are 0.
- R2: A word write to address 0 with upper byte 0x5A loads the low byte into the counter. A word write to address 0 with upper byte 0xA5 loads the control register: bit 6 = mode (1 watchdog, 0 interval), bit 5 = run, bits 2:0 = clock select; writing 0 to bit 7 clears the interval flag. Control reads back as {flag, mode, run, 1, 1, select}.
- R3: Byte writes, and word writes with any other upper byte, change neither the counter, the control register nor the reset configuration.
- R4: While run is 1 with clock select s, the counter advances once every 2^(s*TAP_STEP) cycles. The divider restarts from zero whenever run is 0.
- R5: In interval mode a wrap from 0xFF to 0x00 sets control bit 7, pulses irq_o for exactly one cycle, lets the counter continue from 0x00, and leaves reset-control bit 7 clear.
- R6: In watchdog mode a wrap sets reset-control bit 7, and the counter and control register return to their reset values.
- R7: If reset-control bit 6 (enable) is 1 at a watchdog wrap, rst_req_o pulses for one cycle and rst_type_o takes bit 5 (0 power-on, 1 manual). If bit 6 is 0, no request is made.
- R8: A word write to address 2 with upper byte 0x5A loads only bits 6 and 5. Bits 4:0 always read 1, and bit 7 is not written this way.
- R9: Reset-control bit 7 clears only on a word write to address 2 with upper byte 0xA5 and data bit 7 = 0, and only if a read strobe at address 2 has seen it set since it was last set. Without that read, or with data bit 7 = 1, it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address (0 control/shared write, 1 counter, 2 reset control) |
| bus_wdata | input | 16 | Write data: key in the upper byte, payload in the lower byte |
| bus_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (arms the flag-clear handshake) |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_o | output | 1 | Interval overflow interrupt, one-cycle pulse |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |
| rst_type_o | output | 1 | Reset type of the last request (0 power-on, 1 manual) |

## Verification
The bench builds the block with TAP_STEP = 1, so the eight clock selects divide by 1 to 128. This keeps even the slowest select within a few thousand cycles of a wrap and lets every prescaler tap reach an exact overflow-timing check. The widest divider used by the default TAP_STEP = 2 has the same structure, only with longer windows. Keys, data, byte and word sizes, start counts and selects are drawn at random with a fixed seed, around directed cases for the watchdog reset types and the clear handshake.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_RSTC  = 2'd2;

   typedef struct packed {
      logic       iflag;
      logic       wd_mode;
      logic       run;
      logic [2:0] cks;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '{iflag: 1'b0, wd_mode: 1'b0, run: 1'b0, cks: 3'd0};

endpackage

// File: rtl/wdt_keydec.sv
module wdt_keydec
   import wdt_pkg::*;
#(
   parameter int unsigned      REG_W   = 8,
   parameter logic [REG_W-1:0] KEY_CNT = 8'h5A,
   parameter logic [REG_W-1:0] KEY_CTL = 8'hA5
) (
   input  logic                  we,
   input  logic                  word,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [2*REG_W-1:0]    wdata,
   output logic                  ld_cnt,
   output logic                  ld_ctrl,
   output logic                  ld_cfg,
   output logic                  clr_cmd
);

   logic [REG_W-1:0] key;
   logic             wok;

   assign key = wdata[2*REG_W-1:REG_W];
   assign wok = we & word;

   always_comb begin
      ld_cnt  = wok && (addr == ADR_CTRL) && (key == KEY_CNT);
      ld_ctrl = wok && (addr == ADR_CTRL) && (key == KEY_CTL);
      ld_cfg  = wok && (addr == ADR_RSTC) && (key == KEY_CNT);
      clr_cmd = wok && (addr == ADR_RSTC) && (key == KEY_CTL) && !wdata[REG_W-1];
   end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned TAP_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int unsigned NTAP  = 1 << SEL_W;
   localparam int unsigned DIV_W = (NTAP - 1) * TAP_STEP;

   if (TAP_STEP < 1 || DIV_W > 63) begin : g_bad_cfg
      $error("wdt_prescaler: TAP_STEP out of range");
   end

   logic [DIV_W-1:0] div_q;
   logic [NTAP-1:0]  tap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (!run) div_q <= '0;
      else          div_q <= div_q + 1'b1;
   end

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      localparam logic [DIV_W-1:0] TMASK = DIV_W'((64'd1 << (t * TAP_STEP)) - 64'd1);
      if (t == 0) begin : g_every
         assign tap_hit[t] = 1'b1;
      end else begin : g_div
         assign tap_hit[t] = &(div_q | ~TMASK);
      end
   end

   assign tick = run & tap_hit[sel];

   // No tap other than select 0 may fire on two adjacent cycles.
   AST_TAP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && $past(run) && run && $stable(sel) && sel != '0) |-> !tick); // R4

endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_stb,
   input  logic ld_cfg,
   input  logic cfg_en,
   input  logic cfg_sel,
   input  logic clr_cmd,
   input  logic wd_ovf,
   output logic wovf,
   output logic en,
   output logic sel,
   output logic rst_req,
   output logic rst_type
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wovf     <= 1'b0;
         armed    <= 1'b0;
         en       <= 1'b0;
         sel      <= 1'b0;
         rst_req  <= 1'b0;
         rst_type <= 1'b0;
      end else begin
         rst_req <= wd_ovf & en;
         if (wd_ovf && en) rst_type <= sel;
         if (ld_cfg) begin
            en  <= cfg_en;
            sel <= cfg_sel;
         end
         if (wd_ovf) begin
            wovf  <= 1'b1;
            armed <= 1'b0;
         end else if (clr_cmd && armed) begin
            wovf  <= 1'b0;
            armed <= 1'b0;
         end else if (rd_stb && wovf) begin
            armed <= 1'b1;
         end
      end
   end

   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(en)); // R7

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R7

   AST_FLAG_CLR_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wovf) |-> $past(clr_cmd)); // R9

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
   import wdt_pkg::*;
#(
   parameter int unsigned      REG_W    = 8,
   parameter int unsigned      SEL_W    = 3,
   parameter int unsigned      TAP_STEP = 2,
   parameter logic [REG_W-1:0] KEY_CNT  = 8'h5A,
   parameter logic [REG_W-1:0] KEY_CTL  = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   input  logic              bus_word,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   output logic              irq_o,
   output logic              rst_req_o,
   output logic              rst_type_o
);

   if (REG_W != 8 || SEL_W != 3) begin : g_bad_cfg
      $error("wdt_keyed_top: register layout needs REG_W=8 and SEL_W=3");
   end

   localparam logic [REG_W-1:0] CNT_TOP = '1;

   logic             ld_cnt, ld_ctrl, ld_cfg, clr_cmd;
   logic             tick, ovf, wd_ovf;
   logic             wovf, r_en, r_sel;
   logic [REG_W-1:0] cnt_q;
   logic [REG_W-1:0] wlow;
   ctrl_t            ctrl_q;
   logic             irq_q;

   assign wlow = bus_wdata[REG_W-1:0];

   wdt_keydec #(.REG_W(REG_W), .KEY_CNT(KEY_CNT), .KEY_CTL(KEY_CTL)) u_keydec (
      .we      (bus_we),
      .word    (bus_word),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .ld_cnt  (ld_cnt),
      .ld_ctrl (ld_ctrl),
      .ld_cfg  (ld_cfg),
      .clr_cmd (clr_cmd)
   );

   wdt_prescaler #(.SEL_W(SEL_W), .TAP_STEP(TAP_STEP)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q.run),
      .sel   (ctrl_q.cks),
      .tick  (tick)
   );

   assign ovf    = tick && (cnt_q == CNT_TOP);
   assign wd_ovf = ovf && ctrl_q.wd_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ctrl_q <= CTRL_IDLE;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wd_ovf) begin
            cnt_q  <= '0;
            ctrl_q <= CTRL_IDLE;
         end else begin
            if (ld_cnt)    cnt_q <= wlow;
            else if (tick) cnt_q <= cnt_q + 1'b1;
            if (ld_ctrl) begin
               ctrl_q.wd_mode <= wlow[6];
               ctrl_q.run     <= wlow[5];
               ctrl_q.cks     <= wlow[2:0];
               if (!wlow[7]) ctrl_q.iflag <= 1'b0;
            end
            if (ovf) begin
               ctrl_q.iflag <= 1'b1;
               irq_q        <= 1'b1;
            end
         end
      end
   end

   wdt_rstctl u_rstctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (bus_re && (bus_addr == ADR_RSTC)),
      .ld_cfg   (ld_cfg),
      .cfg_en   (wlow[6]),
      .cfg_sel  (wlow[5]),
      .clr_cmd  (clr_cmd),
      .wd_ovf   (wd_ovf),
      .wovf     (wovf),
      .en       (r_en),
      .sel      (r_sel),
      .rst_req  (rst_req_o),
      .rst_type (rst_type_o)
   );

   always_comb begin
      unique case (bus_addr)
         ADR_CTRL:  bus_rdata = {ctrl_q.iflag, ctrl_q.wd_mode, ctrl_q.run, 2'b11, ctrl_q.cks};
         ADR_COUNT: bus_rdata = cnt_q;
         ADR_RSTC:  bus_rdata = {wovf, r_en, r_sel, 5'b11111};
         default:   bus_rdata = '0;
      endcase
   end

   assign irq_o = irq_q;

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R5

   AST_IRQ_NOT_WD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !$past(ctrl_q.wd_mode)); // R5

   AST_BYTE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && !bus_word && !tick) |-> cnt_q == $past(cnt_q)); // R3

   AST_WOVF_WD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wovf) |-> $past(ctrl_q.wd_mode)); // R6

   AST_WD_WRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wovf) |-> (cnt_q == '0 && !ctrl_q.run)); // R6

endmodule

// File: tb/tb_wdt_keyed_top.sv
`timescale 1ns/1ps
module tb_wdt_keyed_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic        bus_word = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic        irq_o, rst_req_o, rst_type_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   wdt_keyed_top #(.TAP_STEP(1)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_word(bus_word), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .rst_req_o(rst_req_o), .rst_type_o(rst_type_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic word);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_word = word; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic rd_strobe(input logic [1:0] a);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   function automatic logic [7:0] ctrl_rd(input logic fl, input logic md, input logic rn,
                                           input logic [2:0] s);
      return {fl, md, rn, 2'b11, s};
   endfunction

   function automatic int wrap_edges(input int start, input int s);
      return (256 - start) << s;
   endfunction

   task automatic interval_trial(input logic [7:0] start, input logic [2:0] s);
      logic [7:0] v;
      int j;
      wr(2'd0, {8'h5A, start}, 1'b1);
      wr(2'd0, {8'hA5, 8'h20 | {5'd0, s}}, 1'b1);
      j = wrap_edges(start, s);
      repeat (j - 1) @(negedge clk);
      check("R5 irq before wrap", {15'd0, irq_o}, 16'd0);
      peek(2'd0, v); check("R5 flag before wrap", {8'd0, v}, {8'd0, ctrl_rd(1'b0, 1'b0, 1'b1, s)});
      @(negedge clk);
      check("R5 irq at wrap", {15'd0, irq_o}, 16'd1);
      peek(2'd0, v); check("R5 flag at wrap", {8'd0, v}, {8'd0, ctrl_rd(1'b1, 1'b0, 1'b1, s)});
      peek(2'd1, v); check("R5 counter continues", {8'd0, v}, 16'h0000);
      peek(2'd2, v); check("R5 no watchdog flag", {15'd0, v[7]}, 16'd0);
      @(negedge clk);
      check("R5 irq single cycle", {15'd0, irq_o}, 16'd0);
      wr(2'd0, 16'hA500, 1'b1);
      peek(2'd0, v); check("R2 stop and clear flag", {8'd0, v}, 16'h0018);
   endtask

   task automatic count_trial(input logic [2:0] s, input int j);
      logic [7:0] v;
      wr(2'd0, 16'h5A00, 1'b1);
      wr(2'd0, {8'hA5, 8'h20 | {5'd0, s}}, 1'b1);
      repeat (j) @(negedge clk);
      peek(2'd1, v);
      check("R4 prescaled count", {8'd0, v}, 16'((j >> s) & 255));
      wr(2'd0, 16'hA500, 1'b1);
   endtask

   task automatic wd_fire(input logic [7:0] start, input logic [2:0] s,
                          input logic exp_req, input logic exp_type);
      logic [7:0] v;
      int j;
      int seen;
      wr(2'd0, {8'h5A, start}, 1'b1);
      wr(2'd0, {8'hA5, 8'h60 | {5'd0, s}}, 1'b1);
      j = wrap_edges(start, s);
      seen = 0;
      for (int i = 1; i <= j; i++) begin
         @(negedge clk);
         if (i < j) seen += int'(rst_req_o);
      end
      check("R7 no early request", 16'(seen), 16'd0);
      check("R7 request at wrap", {15'd0, rst_req_o}, {15'd0, exp_req});
      if (exp_req) check("R7 reset type", {15'd0, rst_type_o}, {15'd0, exp_type});
      peek(2'd2, v); check("R6 watchdog flag set", {15'd0, v[7]}, 16'd1);
      peek(2'd0, v); check("R6 control back to idle", {8'd0, v}, 16'h0018);
      peek(2'd1, v); check("R6 counter back to zero", {8'd0, v}, 16'h0000);
      @(negedge clk);
      check("R7 request single cycle", {15'd0, rst_req_o}, 16'd0);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] v, e_cnt, e_ctl, lo, up;
      logic wd;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(2'd0, v); check("R1 control reset", {8'd0, v}, 16'h0018);
      peek(2'd1, v); check("R1 counter reset", {8'd0, v}, 16'h0000);
      peek(2'd2, v); check("R1 reset-control reset", {8'd0, v}, 16'h001F);
      check("R1 outputs idle", {13'd0, irq_o, rst_req_o, rst_type_o}, 16'd0);

      // R2 and R3 directed
      wr(2'd0, 16'h5A33, 1'b0);
      peek(2'd1, v); check("R3 byte write to counter", {8'd0, v}, 16'h0000);
      wr(2'd0, 16'h5B44, 1'b1);
      peek(2'd1, v); check("R3 wrong key", {8'd0, v}, 16'h0000);
      wr(2'd0, 16'h5A44, 1'b1);
      peek(2'd1, v); check("R2 counter load", {8'd0, v}, 16'h0044);
      wr(2'd0, 16'hA543, 1'b0);
      peek(2'd0, v); check("R3 byte write to control", {8'd0, v}, 16'h0018);
      wr(2'd0, 16'hA543, 1'b1);
      peek(2'd0, v); check("R2 control load", {8'd0, v}, 16'h005B);
      peek(2'd1, v); check("R2 shared address keeps counter", {8'd0, v}, 16'h0044);
      wr(2'd0, 16'hA500, 1'b1);

      // R3 random keys and sizes on the shared address
      e_cnt = 8'h44; e_ctl = 8'h18;
      for (int t = 0; t < 24; t++) begin
         lo = 8'($urandom) & 8'hDF;
         case ($urandom % 3)
            0: up = 8'h5A;
            1: up = 8'hA5;
            default: up = 8'($urandom);
         endcase
         wd = 1'($urandom);
         wr(2'd0, {up, lo}, wd);
         if (wd && up == 8'h5A) e_cnt = lo;
         if (wd && up == 8'hA5) e_ctl = ctrl_rd(1'b0, lo[6], 1'b0, lo[2:0]);
         peek(2'd1, v); check("R3 random counter", {8'd0, v}, {8'd0, e_cnt});
         peek(2'd0, v); check("R3 random control", {8'd0, v}, {8'd0, e_ctl});
      end
      wr(2'd0, 16'hA500, 1'b1);

      // R8 reset-control configuration
      wr(2'd2, 16'h5A60, 1'b0);
      peek(2'd2, v); check("R3 byte write to reset control", {8'd0, v}, 16'h001F);
      wr(2'd2, 16'hA560, 1'b1);
      peek(2'd2, v); check("R8 clear key leaves config", {8'd0, v}, 16'h001F);
      wr(2'd2, 16'h5AE0, 1'b1);
      peek(2'd2, v); check("R8 config load", {8'd0, v}, 16'h007F);
      wr(2'd2, 16'h5A00, 1'b1);
      peek(2'd2, v); check("R8 low bits read one", {8'd0, v}, 16'h001F);

      // R4 prescaler across selects
      for (int s = 0; s < 8; s++) count_trial(3'(s), 1 + int'($urandom % 300));

      // R5 interval wraps, directed and random
      interval_trial(8'hFE, 3'd0);
      interval_trial(8'hF0, 3'd3);
      for (int t = 0; t < 8; t++)
         interval_trial(8'(256 - (1 + int'($urandom % 32))), 3'($urandom));

      // R6 and R7 without reset enable, then R9 handshake
      wd_fire(8'hFD, 3'd1, 1'b0, 1'b0);
      wr(2'd2, 16'hA500, 1'b1);
      peek(2'd2, v); check("R9 clear without read", {8'd0, v}, 16'h009F);
      rd_strobe(2'd2);
      wr(2'd2, 16'hA580, 1'b1);
      peek(2'd2, v); check("R9 write of one keeps flag", {8'd0, v}, 16'h009F);
      wr(2'd2, 16'hA500, 1'b0);
      peek(2'd2, v); check("R9 byte clear ignored", {8'd0, v}, 16'h009F);
      wr(2'd2, 16'hA500, 1'b1);
      peek(2'd2, v); check("R9 clear after read", {8'd0, v}, 16'h001F);

      // R7 manual then power-on reset requests
      wr(2'd2, 16'h5A60, 1'b1);
      wd_fire(8'hFE, 3'd0, 1'b1, 1'b1);
      wr(2'd2, 16'h5A40, 1'b1);
      wd_fire(8'hF8, 3'd2, 1'b1, 1'b0);
      peek(2'd2, v); check("R9 flag stays set without clear", {15'd0, v[7]}, 16'd1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule